// File: doc/BRIEF.md
# Feedback Tap and Seed Cycle-Length Sweeper

This block holds a nine-stage shift register whose first stage is fed by the XOR of the last stage and one further stage, chosen by a 3-bit code. A controller built around it measures how many shifts the register takes to return to the value it was loaded with. It runs two sweeps in sequence after a single start pulse.

The first sweep loads seed 1 under each of the eight tap codes and keeps the code whose cycle is shortest. The second sweep keeps that code fixed and measures every nonzero seed from 1 to 511 in ascending order. It keeps the seed with the shortest cycle of at least two shifts. Each measurement is reported with a one-cycle strobe that carries the tap code, the seed and the period. A one-cycle done flag marks the end of the run, and the two winners stay in holding registers until the next start or reset.

Top module: `cycle_sweep_analyzer`

## Requirements
- R1: Stage k is bit k-1 of the state and of a seed. On each shift stage k moves to stage k+1, and stage 1 takes stage 9 XOR stage c+1, where c is the active tap code (0 to 7).
- R2: Before each measurement the register is loaded in parallel with the seed under test, and it does not shift in that cycle. The zero seed is never loaded.
- R3: The reported period `resPeriod` is the number of shifts after the load until the register holds the seed again. It is never zero.
- R4: After start, the first sweep reports exactly eight strobes with seed 1 and tap codes 0, 1, ..., 7 in ascending order.
- R5: At the end of the first sweep, `bestTap` holds the code with the smallest period and `bestTapPeriod` holds that period. On a tie the lowest code wins.
- R6: The second sweep reports exactly 511 strobes under tap code `bestTap`, with seeds 1, 2, ..., 511 in ascending order.
- R7: At the end, `bestSeed` holds the seed with the smallest period of at least 2 and `bestSeedPeriod` holds that period. On a tie the lowest seed wins.
- R8: Each result strobe lasts one cycle. `doneFlag` is high for exactly one cycle, the cycle after the last strobe of the second sweep.
- R9: A start pulse that arrives while a sweep is running has no effect. The strobe sequence continues unchanged.
- R10: A synchronous active-high reset returns the block to idle. It drops `resValid` and `doneFlag` and sets all four best-result outputs to all ones. No strobe follows until the next start.
- R11: Under tap code 4 (stages 9 and 5), seed 1 has a period of 511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Start pulse; acted on only when idle |
| resValid | output | 1 | One-cycle strobe for a finished measurement |
| resTap | output | 3 | Tap code of the reported measurement |
| resSeed | output | 9 | Seed of the reported measurement |
| resPeriod | output | 9 | Measured period |
| doneFlag | output | 1 | One-cycle pulse at the end of the second sweep |
| bestTap | output | 3 | Winning tap code of the first sweep |
| bestTapPeriod | output | 9 | Period of the winning tap code |
| bestSeed | output | 9 | Winning seed of the second sweep |
| bestSeedPeriod | output | 9 | Period of the winning seed |

## Verification
The bench compares every strobe against a period model written from R1. An off-by-one count, a wrong tap mapping such as using stage c instead of c+1, or a wrong shift direction would therefore show up as wrong periods, most visibly as tap code 4 failing to give 511. It also checks that the second sweep picks up the winning tap and starts at seed 1 and not seed 0. A design that compares with less-or-equal would report a later tap or seed on ties. Start pulses are injected during both sweeps, and a restarting design would repeat tap 0 or seed 1. A reset is also applied in the middle of a run, where a design that kept stale winners or went on strobing would be caught.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_ADV
  } ctlState_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic initSweep;   // reset tap, seed and winners for a new run
    logic load;        // parallel load of the seed
    logic shift;       // one shift step, count it
    logic finish;      // capture result, update winner
    logic phaseTwo;    // selects which winner the finish updates
    logic nextTap;     // step to the next tap code
    logic enterTwo;    // switch to the winning tap, seed back to 1
    logic nextSeed;    // step to the next seed
  } ctrlStrobe_t;

  // status from the datapath to the controller
  typedef struct packed {
    logic hit;         // register back at the seed
    logic timeout;     // guard limit reached
    logic tapLast;     // tap code at its highest value
    logic seedLast;    // seed at its highest value
  } dpStatus_t;

endpackage

// File: rtl/lfsr_core.sv
module lfsr_core #(
  parameter int STAGES   = 9,
  parameter int TAP_BITS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                shift,
  input  logic [STAGES-1:0]   seedVal,
  input  logic [TAP_BITS-1:0] tapSel,
  output logic [STAGES-1:0]   state
);

  logic [STAGES-1:0] stateQ;
  logic [STAGES-1:0] nextVec;
  logic              feedBack;

  // last stage always takes part, the selected stage is the second input
  assign feedBack = stateQ[STAGES-1] ^ stateQ[tapSel];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign nextVec[k] = load ? seedVal[k] : feedBack;
    end else begin : g_rest
      assign nextVec[k] = load ? seedVal[k] : stateQ[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= '0;
    end else if (load || shift) begin
      stateQ <= nextVec;
    end
  end

  assign state = stateQ;

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (stateQ == $past(seedVal)));

  p_shift_r1: assert property (@(posedge clk) disable iff (rst)
    (shift && !load) |=> (stateQ[STAGES-1:1] == $past(stateQ[STAGES-2:0])));

  p_seed_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    load |-> (seedVal != '0));

endmodule

// File: rtl/sweep_datapath.sv
module sweep_datapath
  import sweep_pkg::*;
#(
  parameter int STAGES   = 9,
  parameter int TAP_BITS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobe_t         ctrl,
  output dpStatus_t           status,
  output logic                resValid,
  output logic [TAP_BITS-1:0] resTap,
  output logic [STAGES-1:0]   resSeed,
  output logic [STAGES-1:0]   resPeriod,
  output logic [TAP_BITS-1:0] bestTap,
  output logic [STAGES-1:0]   bestTapPeriod,
  output logic [STAGES-1:0]   bestSeed,
  output logic [STAGES-1:0]   bestSeedPeriod
);

  localparam int CNT_W = STAGES + 1;
  localparam logic [STAGES-1:0] SEED_ONE = {{(STAGES-1){1'b0}}, 1'b1};

  logic [TAP_BITS-1:0] tapCode;
  logic [STAGES-1:0]   seedReg;
  logic [CNT_W-1:0]    shiftCnt;
  logic [STAGES-1:0]   lfsrState;
  logic [STAGES-1:0]   periodNow;
  logic                tapBetter;
  logic                seedBetter;

  lfsr_core #(.STAGES(STAGES), .TAP_BITS(TAP_BITS)) u_lfsr (
    .clk    (clk),
    .rst    (rst),
    .load   (ctrl.load),
    .shift  (ctrl.shift),
    .seedVal(seedReg),
    .tapSel (tapCode),
    .state  (lfsrState)
  );

  // saturate on the guard limit so the report stays in range
  assign periodNow  = shiftCnt[STAGES] ? '1 : shiftCnt[STAGES-1:0];
  assign tapBetter  = periodNow < bestTapPeriod;
  assign seedBetter = (periodNow > SEED_ONE) && (periodNow < bestSeedPeriod);

  assign status.hit      = (shiftCnt != '0) && (lfsrState == seedReg);
  assign status.timeout  = shiftCnt[STAGES];
  assign status.tapLast  = (tapCode == '1);
  assign status.seedLast = (seedReg == '1);

  // tap and seed under test
  always_ff @(posedge clk) begin
    if (rst) begin
      tapCode <= '0;
      seedReg <= SEED_ONE;
    end else if (ctrl.initSweep) begin
      tapCode <= '0;
      seedReg <= SEED_ONE;
    end else if (ctrl.nextTap) begin
      tapCode <= tapCode + 1'b1;
    end else if (ctrl.enterTwo) begin
      tapCode <= bestTap;
      seedReg <= SEED_ONE;
    end else if (ctrl.nextSeed) begin
      seedReg <= seedReg + 1'b1;
    end
  end

  // shift counter
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftCnt <= '0;
    end else if (ctrl.load) begin
      shiftCnt <= '0;
    end else if (ctrl.shift) begin
      shiftCnt <= shiftCnt + 1'b1;
    end
  end

  // result strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      resValid  <= 1'b0;
      resTap    <= '0;
      resSeed   <= '0;
      resPeriod <= '0;
    end else begin
      resValid <= ctrl.finish;
      if (ctrl.finish) begin
        resTap    <= tapCode;
        resSeed   <= seedReg;
        resPeriod <= periodNow;
      end
    end
  end

  // winners, strict compare keeps the first one found
  always_ff @(posedge clk) begin
    if (rst || ctrl.initSweep) begin
      bestTap        <= '1;
      bestTapPeriod  <= '1;
      bestSeed       <= '1;
      bestSeedPeriod <= '1;
    end else if (ctrl.finish) begin
      if (!ctrl.phaseTwo && tapBetter) begin
        bestTap       <= tapCode;
        bestTapPeriod <= periodNow;
      end
      if (ctrl.phaseTwo && seedBetter) begin
        bestSeed       <= seedReg;
        bestSeedPeriod <= periodNow;
      end
    end
  end

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
    resValid |=> !resValid);

  p_period_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (resPeriod != '0));

  p_tap_monotone_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl.initSweep |=> (bestTapPeriod <= $past(bestTapPeriod)));

  p_seed_monotone_r7: assert property (@(posedge clk) disable iff (rst)
    !ctrl.initSweep |=> (bestSeedPeriod <= $past(bestSeedPeriod)));

endmodule

// File: rtl/sweep_control.sv
module sweep_control
  import sweep_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        startReq,
  input  dpStatus_t   status,
  output ctrlStrobe_t ctrl,
  output logic        doneFlag
);

  ctlState_t state;
  ctlState_t stateNext;
  logic      phaseTwo;
  logic      lastSeedDone;

  assign lastSeedDone = (state == ST_ADV) && phaseTwo && status.seedLast;

  always_comb begin
    ctrl          = '0;
    ctrl.phaseTwo = phaseTwo;
    stateNext     = state;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          ctrl.initSweep = 1'b1;
          stateNext      = ST_LOAD;
        end
      end
      ST_LOAD: begin
        ctrl.load = 1'b1;
        stateNext = ST_RUN;
      end
      ST_RUN: begin
        if (status.hit || status.timeout) begin
          ctrl.finish = 1'b1;
          stateNext   = ST_ADV;
        end else begin
          ctrl.shift = 1'b1;
        end
      end
      ST_ADV: begin
        if (!phaseTwo) begin
          if (status.tapLast) ctrl.enterTwo = 1'b1;
          else                ctrl.nextTap  = 1'b1;
          stateNext = ST_LOAD;
        end else if (status.seedLast) begin
          stateNext = ST_IDLE;
        end else begin
          ctrl.nextSeed = 1'b1;
          stateNext     = ST_LOAD;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phaseTwo <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      state    <= stateNext;
      doneFlag <= lastSeedDone;
      if (ctrl.initSweep)     phaseTwo <= 1'b0;
      else if (ctrl.enterTwo) phaseTwo <= 1'b1;
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    doneFlag |=> !doneFlag);

  p_run_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |=> (state == ST_RUN || state == ST_ADV));

  p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && startReq) |=> (state != ST_LOAD || $past(state) == ST_ADV));

endmodule

// File: rtl/cycle_sweep_analyzer.sv
module cycle_sweep_analyzer
  import sweep_pkg::*;
#(
  parameter int STAGES   = 9,
  parameter int TAP_BITS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                startReq,
  output logic                resValid,
  output logic [TAP_BITS-1:0] resTap,
  output logic [STAGES-1:0]   resSeed,
  output logic [STAGES-1:0]   resPeriod,
  output logic                doneFlag,
  output logic [TAP_BITS-1:0] bestTap,
  output logic [STAGES-1:0]   bestTapPeriod,
  output logic [STAGES-1:0]   bestSeed,
  output logic [STAGES-1:0]   bestSeedPeriod
);

  ctrlStrobe_t ctrl;
  dpStatus_t   status;

  sweep_control u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .startReq(startReq),
    .status  (status),
    .ctrl    (ctrl),
    .doneFlag(doneFlag)
  );

  sweep_datapath #(.STAGES(STAGES), .TAP_BITS(TAP_BITS)) u_dp (
    .clk           (clk),
    .rst           (rst),
    .ctrl          (ctrl),
    .status        (status),
    .resValid      (resValid),
    .resTap        (resTap),
    .resSeed       (resSeed),
    .resPeriod     (resPeriod),
    .bestTap       (bestTap),
    .bestTapPeriod (bestTapPeriod),
    .bestSeed      (bestSeed),
    .bestSeedPeriod(bestSeedPeriod)
  );

endmodule

// File: tb/tb_cycle_sweep_analyzer.sv
module tb_cycle_sweep_analyzer;

  logic       clk = 1'b0;
  logic       rst;
  logic       startReq;
  logic       resValid;
  logic [2:0] resTap;
  logic [8:0] resSeed;
  logic [8:0] resPeriod;
  logic       doneFlag;
  logic [2:0] bestTap;
  logic [8:0] bestTapPeriod;
  logic [8:0] bestSeed;
  logic [8:0] bestSeedPeriod;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int expTap;
  int expTapPer;
  int expSeed;
  int expSeedPer;

  always #5 clk = ~clk;

  cycle_sweep_analyzer dut (
    .clk(clk), .rst(rst), .startReq(startReq),
    .resValid(resValid), .resTap(resTap), .resSeed(resSeed), .resPeriod(resPeriod),
    .doneFlag(doneFlag), .bestTap(bestTap), .bestTapPeriod(bestTapPeriod),
    .bestSeed(bestSeed), .bestSeedPeriod(bestSeedPeriod)
  );

  // model from R1: new stage 1 = stage 9 ^ stage (code+1)
  function automatic logic [8:0] stepModel(logic [8:0] s, int code);
    return {s[7:0], s[8] ^ s[code]};
  endfunction

  function automatic int periodModel(logic [8:0] seed, int code);
    logic [8:0] s;
    int n;
    s = stepModel(seed, code);
    n = 1;
    while (s != seed && n < 600) begin
      s = stepModel(s, code);
      n++;
    end
    return n;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitStrobe();
    do @(negedge clk); while (!resValid);
  endtask

  task automatic pulseStart();
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic testReset();
    rst = 1'b1;
    startReq = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(resValid == 1'b0, "R10 resValid after reset", resValid, 0);
    check(doneFlag == 1'b0, "R10 doneFlag after reset", doneFlag, 0);
    check({bestTap, bestTapPeriod, bestSeed, bestSeedPeriod} == '1,
          "R10 winners all ones", bestTapPeriod, 511);
  endtask

  task automatic testFullSweep(input bit inject);
    int per;
    pulseStart();
    for (int t = 0; t < 8; t++) begin
      waitStrobe();
      per = periodModel(9'd1, t);
      check(resTap == t[2:0] && resSeed == 9'd1, "R4 tap order and seed", resTap, t);
      check(resPeriod == per[8:0], "R1 R3 phase one period", resPeriod, per);
      if (t == 4) check(resPeriod == 9'd511, "R11 tap 4 maximal", resPeriod, 511);
      if (inject && t == 2) pulseStart();
    end
    for (int s = 1; s < 512; s++) begin
      waitStrobe();
      per = periodModel(s[8:0], expTap);
      check(resTap == expTap[2:0] && resSeed == s[8:0], "R6 R2 seed order", resSeed, s);
      check(resPeriod == per[8:0], "R1 R3 phase two period", resPeriod, per);
      if (inject && s == 100) pulseStart();
      if (inject && s == 100) check(!resValid, "R9 no restart strobe", resValid, 0);
    end
    @(negedge clk);
    check(doneFlag == 1'b1, "R8 done after last strobe", doneFlag, 1);
    check(resValid == 1'b0, "R8 strobe one cycle", resValid, 0);
    @(negedge clk);
    check(doneFlag == 1'b0, "R8 done one cycle", doneFlag, 0);
    check(bestTap == expTap[2:0], "R5 best tap", bestTap, expTap);
    check(bestTapPeriod == expTapPer[8:0], "R5 best tap period", bestTapPeriod, expTapPer);
    check(bestSeed == expSeed[8:0], "R7 best seed", bestSeed, expSeed);
    check(bestSeedPeriod == expSeedPer[8:0], "R7 best seed period", bestSeedPeriod, expSeedPer);
  endtask

  task automatic testMidReset();
    int seen;
    pulseStart();
    repeat (3) waitStrobe();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(resValid == 1'b0 && doneFlag == 1'b0, "R10 outputs quiet", resValid, 0);
    check({bestTap, bestTapPeriod, bestSeed, bestSeedPeriod} == '1,
          "R10 winners cleared", bestSeed, 511);
    seen = 0;
    repeat (60) begin
      @(negedge clk);
      if (resValid || doneFlag) seen++;
    end
    check(seen == 0, "R10 idle after reset", seen, 0);
  endtask

  initial begin
    int per;
    rst = 1'b1;
    startReq = 1'b0;
    expTap = 7;
    expTapPer = 511;
    for (int t = 0; t < 8; t++) begin
      per = periodModel(9'd1, t);
      if (per < expTapPer) begin expTapPer = per; expTap = t; end
    end
    expSeed = 511;
    expSeedPer = 511;
    for (int s = 1; s < 512; s++) begin
      per = periodModel(s[8:0], expTap);
      if (per >= 2 && per < expSeedPer) begin expSeedPer = per; expSeed = s; end
    end
    testReset();
    testFullSweep(1'b1);
    testMidReset();
    testFullSweep(1'b0);
    testReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule